// File: doc/BRIEF.md
# Four-Wide In-Order Issue Hazard Gate

This block decides, every cycle, how many instructions of a decoded packet may leave the issue stage of a statically scheduled superscalar pipeline. A packet holds up to four slots. Each slot carries two source register numbers, one destination register number and a one-bit functional-unit class. The block also sees a busy bit for every architectural register, standing for results still in execution, and a free-unit count for each class. It answers with a per-slot issue enable and an issue count. The enables always form a run that starts at slot 0. The first slot that meets a hazard stops the run, and every slot after it waits as well.

The check is split over two registered stages. The first stage holds the incoming packet and works out how many of its leading slots are free of read-after-write dependences on earlier slots of the same packet. That result is registered. The second stage then tests those leading slots against the busy scoreboard and the free-unit counts. Slots that do not issue stay in the second stage. They are moved down to slot 0 and checked again in the next cycle, and the dependence test is rerun on the slots that remain.

Packets arrive on a valid/ready interface. A packet is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the first stage is empty, or when the second stage will hand over its whole content at the coming edge. While `in_ready` is low, upstream must hold the packet. The block never drops a packet and never takes one twice. `flush` is a plain control pin that empties both stages.

Top module: `issue_gate`

## Requirements
- R1: After reset, `issue_en` and `issue_cnt` are zero and `in_ready` is high.
- R2: A packet is taken only when `in_valid` and `in_ready` are both high. While the first stage holds a packet that cannot advance, `in_ready` is low and the held packet is kept unchanged.
- R3: A packet taken at clock edge k is presented for issue in the cycle that follows edge k+1. Hazard-free packets sent back to back issue in consecutive cycles, and `in_ready` stays high while they do.
- R4: `issue_en` is a contiguous run of ones starting at bit 0, and `issue_cnt` equals the number of ones in it. A slot issues only when every earlier valid slot issues in the same cycle.
- R5: A slot is held when either of its source registers equals the destination of an earlier slot that is still in the packet.
- R6: A slot is held when `busy[r]` is 1 for either of its source registers r.
- R7: The class field is 0 or 1, and `unit_free[c]` gives the number of free units of class c. A slot of class c is held when the number of slots of class c, up to and including it, is greater than `unit_free[c]`.
- R8: Slots that are not issued move down by the issue count. In the next cycle they are checked again from slot 0. A dependence on a slot that has already issued no longer holds them.
- R9: During a cycle with `flush` high, nothing issues and `in_ready` is low. After that edge both stages are empty, so nothing issues in the next cycle either.
- R10: `in_slot_v` must be a run of ones starting at bit 0 with at least one bit set. A slot that is not valid never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties both stages |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet taken at this edge when valid is high |
| in_slot_v | input | 4 | Per-slot valid bits, a run starting at bit 0 |
| in_src_a | input | 4x3 | First source register number of each slot |
| in_src_b | input | 4x3 | Second source register number of each slot |
| in_dst | input | 4x3 | Destination register number of each slot |
| in_cls | input | 4x1 | Functional-unit class of each slot |
| busy | input | 8 | One bit per register; 1 means a result is still pending |
| unit_free | input | 2x2 | Number of free units of each class, 0 to 3 |
| issue_en | output | 4 | Per-slot issue enable for the second-stage packet |
| issue_cnt | output | 3 | Number of slots issued this cycle |

## Verification
The assertions assume that upstream follows the interface rules. Valid bits must form a run starting at slot 0, and a packet that is not accepted must stay unchanged. The busy vector and the free-unit counts only move between clock edges. The bench builds its valid masks from a length from one to four. It changes its inputs only on falling edges. After a hold it waits for the next falling edge before it releases the scoreboard, so that every check is made against inputs that were stable for the whole cycle.

// File: rtl/issue_pkg.sv
package issue_pkg;
  parameter int SLOTS = 4;
  parameter int RW    = 3;
  parameter int CLW   = 1;
  parameter int UW    = 2;
  localparam int NREG = 1 << RW;
  localparam int NCLS = 1 << CLW;
  localparam int CW   = $clog2(SLOTS + 1);
  typedef logic [RW-1:0]  reg_t;
  typedef logic [CLW-1:0] cls_t;
endpackage

// File: rtl/intra_dep.sv
module intra_dep import issue_pkg::*; (
  input  logic [SLOTS-1:0] slot_v,
  input  reg_t [SLOTS-1:0] src_a,
  input  reg_t [SLOTS-1:0] src_b,
  input  reg_t [SLOTS-1:0] dst,
  output logic [SLOTS-1:0] ok_mask
);
  logic [SLOTS-1:0] clean;

  // a slot is clean when valid and no earlier slot writes one of its sources
  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      clean[j] = slot_v[j];
      for (int i = 0; i < j; i++)
        if (dst[i] == src_a[j] || dst[i] == src_b[j]) clean[j] = 1'b0;
    end
  end

  // leading run of clean slots
  always_comb begin
    logic run;
    run = 1'b1;
    for (int j = 0; j < SLOTS; j++) begin
      run        = run & clean[j];
      ok_mask[j] = run;
    end
  end
endmodule

// File: rtl/res_check.sv
module res_check import issue_pkg::*; (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS-1:0]          cand,
  input  reg_t [SLOTS-1:0]          src_a,
  input  reg_t [SLOTS-1:0]          src_b,
  input  cls_t [SLOTS-1:0]          cls,
  input  logic [NREG-1:0]           busy,
  input  logic [NCLS-1:0][UW-1:0]   unit_free,
  input  logic                      kill,
  output logic [SLOTS-1:0]          en,
  output logic [CW-1:0]             cnt
);
  logic [SLOTS-1:0] good;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [CW-1:0] same;
    logic          over;
    logic          src_busy;

    always_comb begin
      same = '0;
      for (int k = 0; k <= g; k++)
        if (cls[k] == cls[g]) same = same + CW'(1);
    end

    assign over     = same > CW'(unit_free[cls[g]]);
    assign src_busy = busy[src_a[g]] | busy[src_b[g]];
    assign good[g]  = cand[g] & ~over & ~src_busy;

    // R6
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en[g] |-> !busy[src_a[g]] && !busy[src_b[g]]);
    // R5
    intra_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en[g] |-> cand[g]);
  end

  // in-order prefix and count
  always_comb begin
    logic run;
    run = ~kill;
    cnt = '0;
    for (int j = 0; j < SLOTS; j++) begin
      run   = run & good[j];
      en[j] = run;
      cnt   = cnt + CW'(run);
    end
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [SLOTS-1:0] in_c;
    always_comb
      for (int j = 0; j < SLOTS; j++) in_c[j] = (cls[j] == cls_t'(c));
    // R7
    unit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(en & in_c) <= int'(unit_free[c]));
  end
endmodule

// File: rtl/issue_gate.sv
module issue_gate import issue_pkg::*; (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [SLOTS-1:0]              in_slot_v,
  input  logic [SLOTS-1:0][RW-1:0]      in_src_a,
  input  logic [SLOTS-1:0][RW-1:0]      in_src_b,
  input  logic [SLOTS-1:0][RW-1:0]      in_dst,
  input  logic [SLOTS-1:0][CLW-1:0]     in_cls,
  input  logic [NREG-1:0]               busy,
  input  logic [NCLS-1:0][UW-1:0]       unit_free,
  output logic [SLOTS-1:0]              issue_en,
  output logic [CW-1:0]                 issue_cnt
);
  // stage 1: raw packet
  logic [SLOTS-1:0] s1_v;
  reg_t [SLOTS-1:0] s1_ra, s1_rb, s1_rd;
  cls_t [SLOTS-1:0] s1_cl;
  logic [SLOTS-1:0] s1_ok;
  // stage 2: packet under check, with registered intra-packet result
  logic [SLOTS-1:0] s2_v, s2_ok;
  reg_t [SLOTS-1:0] s2_ra, s2_rb, s2_rd;
  cls_t [SLOTS-1:0] s2_cl;
  // leftover after this cycle's issue
  logic [SLOTS-1:0] sh_v, sh_ok;
  reg_t [SLOTS-1:0] sh_ra, sh_rb, sh_rd;
  cls_t [SLOTS-1:0] sh_cl;
  logic             s2_take;

  intra_dep u_dep_new (
    .slot_v (s1_v), .src_a (s1_ra), .src_b (s1_rb), .dst (s1_rd),
    .ok_mask(s1_ok)
  );

  res_check u_res (
    .clk (clk), .rst_n (rst_n), .cand (s2_ok),
    .src_a (s2_ra), .src_b (s2_rb), .cls (s2_cl),
    .busy (busy), .unit_free (unit_free), .kill (flush),
    .en (issue_en), .cnt (issue_cnt)
  );

  always_comb begin
    sh_v = '0; sh_ra = '0; sh_rb = '0; sh_rd = '0; sh_cl = '0;
    for (int j = 0; j < SLOTS; j++)
      for (int k = 0; k < SLOTS; k++)
        if (k == j + int'(issue_cnt)) begin
          sh_v[j]  = s2_v[k];
          sh_ra[j] = s2_ra[k];
          sh_rb[j] = s2_rb[k];
          sh_rd[j] = s2_rd[k];
          sh_cl[j] = s2_cl[k];
        end
  end

  intra_dep u_dep_left (
    .slot_v (sh_v), .src_a (sh_ra), .src_b (sh_rb), .dst (sh_rd),
    .ok_mask(sh_ok)
  );

  assign s2_take  = (issue_en == s2_v);
  assign in_ready = !flush && (s1_v == '0 || s2_take);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      s1_v <= '0; s2_v <= '0; s2_ok <= '0;
    end else begin
      if (s2_take) begin
        s2_v <= s1_v;   s2_ok <= s1_ok;
        s2_ra <= s1_ra; s2_rb <= s1_rb; s2_rd <= s1_rd; s2_cl <= s1_cl;
      end else begin
        s2_v <= sh_v;   s2_ok <= sh_ok;
        s2_ra <= sh_ra; s2_rb <= sh_rb; s2_rd <= sh_rd; s2_cl <= sh_cl;
      end
      if (in_valid && in_ready) begin
        s1_v <= in_slot_v;
        s1_ra <= in_src_a; s1_rb <= in_src_b; s1_rd <= in_dst; s1_cl <= in_cls;
      end else if (s2_take) begin
        s1_v <= '0;
      end
    end
  end

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> issue_cnt == '0);
  // R8
  left_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && issue_cnt != '0 && issue_en != s2_v) |=>
      s2_v == ($past(s2_v) >> $past(issue_cnt)));
  // R2
  s1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v != '0 && !s2_take && !flush) |=>
      $stable(s1_v) && $stable(s1_ra) && $stable(s1_rb) && $stable(s1_rd));
  // R10
  en_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en & ~s2_v) == '0);
endmodule

// File: tb/tb_issue_gate.sv
module tb_issue_gate;
  import issue_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SLOTS-1:0] in_slot_v = '0;
  logic [SLOTS-1:0][RW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [SLOTS-1:0][CLW-1:0] in_cls = '0;
  logic [NREG-1:0] busy = '0;
  logic [NCLS-1:0][UW-1:0] unit_free = '0;
  logic [SLOTS-1:0] issue_en;
  logic [CW-1:0] issue_cnt;

  int checks = 0, fails = 0, cycles = 0;
  int ra_q[SLOTS], rb_q[SLOTS], rd_q[SLOTS], cl_q[SLOTS], free_q[NCLS];
  int rm;

  issue_gate dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_slot_v(in_slot_v), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_dst(in_dst), .in_cls(in_cls), .busy(busy),
    .unit_free(unit_free), .issue_en(issue_en), .issue_cnt(issue_cnt)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog got=%0d exp=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic set_free(input int a, input int b);
    free_q[0] = a; free_q[1] = b;
    unit_free[0] = UW'(a); unit_free[1] = UW'(b);
  endtask

  // expected leading issue count of the remaining slots
  function automatic int model(output string why);
    int same;
    why = "R4";
    for (int j = 0; j < rm; j++) begin
      bit raw = 1'b0;
      for (int i = 0; i < j; i++)
        if (rd_q[i] == ra_q[j] || rd_q[i] == rb_q[j]) raw = 1'b1;
      same = 0;
      for (int k = 0; k <= j; k++) if (cl_q[k] == cl_q[j]) same++;
      if (raw) begin why = "R5"; return j; end
      if (busy[ra_q[j]] || busy[rb_q[j]]) begin why = "R6"; return j; end
      if (same > free_q[cl_q[j]]) begin why = "R7"; return j; end
    end
    return rm;
  endfunction

  task automatic drive_slot(input int j, input int a, input int b, input int d, input int c);
    ra_q[j] = a; rb_q[j] = b; rd_q[j] = d; cl_q[j] = c;
    in_src_a[j] = RW'(a); in_src_b[j] = RW'(b); in_dst[j] = RW'(d); in_cls[j] = CLW'(c);
  endtask

  task automatic run_packet();
    int m, n;
    bit release_pending;
    string why;
    @(negedge clk);
    m = 1 + int'($urandom % 4);
    busy = NREG'($urandom & $urandom & $urandom);
    set_free(int'($urandom % 4), int'($urandom % 4));
    for (int j = 0; j < SLOTS; j++)
      drive_slot(j, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 2));
    rm = m;
    in_slot_v = SLOTS'((1 << m) - 1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    release_pending = 1'b0;
    for (int step = 0; step < 12 && rm > 0; step++) begin
      if (release_pending) begin
        busy = '0; set_free(3, 3); release_pending = 1'b0;
      end
      #1;
      n = model(why);
      check(step > 0 ? "R8" : why, int'(issue_cnt), n);
      check("R4", int'(issue_en), (1 << n) - 1);
      if (m < SLOTS) check("R10", int'(issue_en) >> m, 0);
      for (int j = 0; j < SLOTS; j++)
        if (j + n < SLOTS) begin
          ra_q[j] = ra_q[j+n]; rb_q[j] = rb_q[j+n]; rd_q[j] = rd_q[j+n]; cl_q[j] = cl_q[j+n];
        end
      rm -= n;
      if (n == 0) release_pending = 1'b1;
      if (rm > 0) @(negedge clk);
    end
    check("R8", rm, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    check("R1", int'(issue_cnt), 0);
    check("R1", int'(issue_en), 0);
    check("R1", int'(in_ready), 1);

    // R3: hazard-free back-to-back stream
    busy = '0; set_free(3, 3);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k < 8) begin
        for (int j = 0; j < SLOTS; j++) drive_slot(j, 0, 0, j + 1, j % 2);
        in_slot_v = SLOTS'((1 << ((k % 4) + 1)) - 1);
        in_valid = 1'b1;
      end else in_valid = 1'b0;
      #1;
      if (k < 8) check("R3", int'(in_ready), 1);
      if (k >= 2) check("R3", int'(issue_cnt), ((k - 2) % 4) + 1);
    end
    repeat (3) @(negedge clk);

    // R2: back-pressure while the second stage is held
    busy = '1; set_free(3, 3);
    for (int j = 0; j < SLOTS; j++) drive_slot(j, 1, 2, j + 3, 0);
    in_slot_v = 4'b0011; in_valid = 1'b1;
    @(negedge clk);
    in_slot_v = 4'b0001;
    @(negedge clk); #1;
    check("R6", int'(issue_cnt), 0);
    check("R2", int'(in_ready), 0);
    @(negedge clk); #1;
    check("R2", int'(in_ready), 0);
    in_valid = 1'b0;
    @(negedge clk);
    busy = '0; #1;
    check("R2", int'(issue_cnt), 2);
    @(negedge clk); #1;
    check("R2", int'(issue_en), 1);
    @(negedge clk); #1;
    check("R2", int'(issue_cnt), 0);

    // R9: flush empties both stages
    busy = '1;
    in_slot_v = 4'b0111; in_valid = 1'b1;
    @(negedge clk);
    in_slot_v = 4'b0001;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    flush = 1'b1; busy = '0; #1;
    check("R9", int'(issue_cnt), 0);
    check("R9", int'(in_ready), 0);
    @(negedge clk);
    flush = 1'b0; #1;
    check("R9", int'(issue_cnt), 0);
    check("R9", int'(in_ready), 1);
    @(negedge clk); #1;
    check("R9", int'(issue_cnt), 0);

    // R5 R6 R7 R8 R10: randomized sweep
    for (int p = 0; p < 400; p++) run_packet();

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule